// File: doc/BRIEF.md
# Debug-Safe Register Lock Controller

This block guards a small bank of security-sensitive registers, such as key or integrity-code storage, behind a word of lock bits. Trusted boot firmware sets the lock bits over a simple register bus. Every later bus access to the bank is checked against them. Each protected register has its own read lock and its own write lock. A final self-lock bit freezes the lock word. All lock bits are set-only. Only the power-on reset clears them.

Debug-unlock and scan-mode inputs never clear lock state. On their own they do not open a locked register. The checks are bypassed only while one of those modes is active together with the authenticated-debug qualifier. Blocked accesses return zero or leave the target unchanged, and they raise a one-cycle violation pulse.

Bus timing: a request is sampled on a rising clock edge. Read data and the violation flag are registered and appear in the cycle after the request. With default parameters, addresses 0 to 3 select the protected registers, address 4 selects the lock word, and addresses 5 to 7 are unmapped.

Top module: `reg_lock_ctrl`

## Requirements
- R1: After power-on reset, the lock word, every protected register, `bus_rdata` and `bus_viol` are all zero.
- R2: A write to the lock word address ORs the data into the stored word. Writing zeros never clears a lock bit; only `por_n` low does.
- R3: Lock word layout: bit 2i is the read lock of register i, bit 2i+1 is its write lock, and bit 2·NUM_REGS is the self-lock. Write data above the self-lock bit is discarded, and those bits always read back as zero.
- R4: Once the self-lock bit is set, a write to the lock word leaves it unchanged and raises `bus_viol`.
- R5: A write to a register whose write lock is clear updates it. If the write lock is set, the register is unchanged and `bus_viol` is high for exactly the one cycle after the request.
- R6: A read of a register whose read lock is clear returns its contents in the next cycle. If the read lock is set, the read returns zero and pulses `bus_viol`. A read of the lock word address always returns the lock word, zero-extended.
- R7: A lock bit written in cycle N governs an access presented in cycle N+1.
- R8: While `dbg_auth` is low, any combination of `dbg_unlock` and `scan_mode` leaves the lock word unchanged, and every lock keeps blocking.
- R9: While `dbg_auth` is high and `dbg_unlock` or `scan_mode` is high, register read and write locks are bypassed without a violation. The lock word is never cleared and the self-lock still applies. `dbg_auth` alone bypasses nothing.
- R10: Accesses to unmapped addresses read zero, write nothing and raise no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read request, zero otherwise |
| bus_viol | output | 1 | One-cycle pulse for a blocked access |
| dbg_unlock | input | 1 | Debug-unlock mode |
| scan_mode | input | 1 | Scan-test mode |
| dbg_auth | input | 1 | Authenticated-debug qualifier |

## Verification
The hardest state to reach is a partially locked word combined with live debug and scan inputs. The reason is that an access sees a lock only if the lock was written in an earlier cycle, and the modes must then be swept while locks are in force. The stimulus sets lock bits one at a time. After each bit it sweeps writes and reads over every register, so each read/write lock pairing is exercised. It then cycles through all debug/scan combinations with and without the qualifier, and only sets the self-lock after that. One write lock is deliberately left open, so the self-lock test has a bit it could still have changed. A write to the lock word is also issued back-to-back with a write to the register it guards.

// File: rtl/rlk_pkg.sv
package rlk_pkg;

   // Source of the registered read data
   typedef enum logic [1:0] {
      RSRC_ZERO = 2'd0,
      RSRC_BANK = 2'd1,
      RSRC_CFG  = 2'd2
   } rd_src_e;

   // Per-access decision produced by the checker
   typedef struct packed {
      logic    bank_wr;
      logic    cfg_wr;
      logic    viol;
      rd_src_e rd_src;
   } acc_dec_t;

endpackage

// File: rtl/rlk_lock_store.sv
module rlk_lock_store #(
   parameter int NUM_REGS = 4,
   localparam int LOCK_W  = 2 * NUM_REGS + 1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wr_en,
   input  logic [LOCK_W-1:0] wr_bits,
   output logic [LOCK_W-1:0] lock_word
);

   logic [LOCK_W-1:0] lock_q;

   // Set-only storage: cleared exclusively by power-on reset
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         lock_q <= '0;
      end else if (wr_en) begin
         lock_q <= lock_q | wr_bits;
      end
   end

   assign lock_word = lock_q;

   generate
      for (genvar b = 0; b < LOCK_W; b++) begin : g_sticky
         AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
            lock_q[b] |=> lock_q[b]) else $error("lock bit cleared"); // R2
      end
   endgenerate

   AST_SELF_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!por_n)
      lock_q[LOCK_W-1] |=> $stable(lock_q)) else $error("lock word changed after self-lock"); // R4

endmodule

// File: rtl/rlk_access_check.sv
module rlk_access_check
   import rlk_pkg::*;
#(
   parameter int NUM_REGS     = 4,
   parameter int ADDR_W       = 3,
   parameter bit READ_LOCK_EN = 1'b1,
   parameter bit OVERRIDE_EN  = 1'b1,
   localparam int LOCK_W      = 2 * NUM_REGS + 1,
   localparam int IDX_W       = $clog2(NUM_REGS)
) (
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LOCK_W-1:0] lock_word,
   input  logic              dbg_unlock,
   input  logic              scan_mode,
   input  logic              dbg_auth,
   output logic [IDX_W-1:0]  idx,
   output acc_dec_t          dec
);

   localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(NUM_REGS);

   logic [NUM_REGS-1:0] rd_lock_v;
   logic [NUM_REGS-1:0] wr_lock_v;
   logic                override;
   logic                self_lock;
   logic                hit_bank;
   logic                hit_cfg;
   logic                bank_rd_ok;
   logic                bank_wr_ok;

   // Variant: authenticated debug override present or removed entirely
   generate
      if (OVERRIDE_EN) begin : g_ovr
         assign override = (dbg_unlock | scan_mode) & dbg_auth;
      end else begin : g_no_ovr
         logic unused_dbg;
         assign unused_dbg = dbg_unlock ^ scan_mode ^ dbg_auth;
         assign override   = 1'b0;
      end
   endgenerate

   // Unpack lock word into per-register vectors
   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_unpack
         assign wr_lock_v[i] = lock_word[2*i+1];
         if (READ_LOCK_EN) begin : g_rl
            assign rd_lock_v[i] = lock_word[2*i];
         end else begin : g_no_rl
            logic unused_rl;
            assign unused_rl    = lock_word[2*i];
            assign rd_lock_v[i] = 1'b0;
         end
      end
   endgenerate

   assign self_lock = lock_word[LOCK_W-1];
   assign idx       = addr[IDX_W-1:0];
   assign hit_bank  = req && (addr < CFG_ADDR);
   assign hit_cfg   = req && (addr == CFG_ADDR);

   always_comb begin
      bank_wr_ok = ~wr_lock_v[idx] | override;
      bank_rd_ok = ~rd_lock_v[idx] | override;

      dec.bank_wr = hit_bank & we & bank_wr_ok;
      dec.cfg_wr  = hit_cfg & we & ~self_lock;
      dec.viol    = (hit_bank & we & ~bank_wr_ok)
                  | (hit_bank & ~we & ~bank_rd_ok)
                  | (hit_cfg & we & self_lock);

      if (hit_bank && !we && bank_rd_ok) begin
         dec.rd_src = RSRC_BANK;
      end else if (hit_cfg && !we) begin
         dec.rd_src = RSRC_CFG;
      end else begin
         dec.rd_src = RSRC_ZERO;
      end
   end

endmodule

// File: rtl/rlk_bank.sv
module rlk_bank #(
   parameter int NUM_REGS = 4,
   parameter int DATA_W   = 16,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] regs_q [NUM_REGS];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               regs_q[i] <= '0;
            end else if (wr_en && (idx == IDX_W'(i))) begin
               regs_q[i] <= wr_data;
            end
         end
      end
   endgenerate

   assign rd_data = regs_q[idx];

endmodule

// File: rtl/reg_lock_ctrl.sv
module reg_lock_ctrl
   import rlk_pkg::*;
#(
   parameter int NUM_REGS     = 4,
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = 3,
   parameter bit READ_LOCK_EN = 1'b1,
   parameter bit OVERRIDE_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_viol,
   input  logic              dbg_unlock,
   input  logic              scan_mode,
   input  logic              dbg_auth
);

   localparam int LOCK_W = 2 * NUM_REGS + 1;
   localparam int IDX_W  = $clog2(NUM_REGS);

   initial begin
      AST_PARAM_WIDTH: assert (DATA_W >= LOCK_W) else $error("DATA_W too narrow for lock word");
      AST_PARAM_ADDR:  assert ((1 << ADDR_W) > NUM_REGS) else $error("ADDR_W too small");
      AST_PARAM_REGS:  assert (NUM_REGS >= 2) else $error("NUM_REGS below 2");
   end

   logic [LOCK_W-1:0] lock_word;
   logic [IDX_W-1:0]  idx;
   acc_dec_t          dec;
   logic [DATA_W-1:0] bank_rd;
   logic [DATA_W-1:0] rdata_d;
   logic [DATA_W-1:0] rdata_q;
   logic              viol_q;

   rlk_lock_store #(.NUM_REGS(NUM_REGS)) u_store (
      .clk       (clk),
      .por_n     (por_n),
      .wr_en     (dec.cfg_wr),
      .wr_bits   (bus_wdata[LOCK_W-1:0]),
      .lock_word (lock_word)
   );

   rlk_access_check #(
      .NUM_REGS     (NUM_REGS),
      .ADDR_W       (ADDR_W),
      .READ_LOCK_EN (READ_LOCK_EN),
      .OVERRIDE_EN  (OVERRIDE_EN)
   ) u_chk (
      .req        (bus_req),
      .we         (bus_we),
      .addr       (bus_addr),
      .lock_word  (lock_word),
      .dbg_unlock (dbg_unlock),
      .scan_mode  (scan_mode),
      .dbg_auth   (dbg_auth),
      .idx        (idx),
      .dec        (dec)
   );

   rlk_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .por_n   (por_n),
      .wr_en   (dec.bank_wr),
      .idx     (idx),
      .wr_data (bus_wdata),
      .rd_data (bank_rd)
   );

   always_comb begin
      unique case (dec.rd_src)
         RSRC_BANK: rdata_d = bank_rd;
         RSRC_CFG:  rdata_d = DATA_W'(lock_word);
         default:   rdata_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         rdata_q <= '0;
         viol_q  <= 1'b0;
      end else begin
         rdata_q <= rdata_d;
         viol_q  <= dec.viol;
      end
   end

   assign bus_rdata = rdata_q;
   assign bus_viol  = viol_q;

   AST_VIOL_HAS_REQ: assert property (@(posedge clk) disable iff (!por_n)
      bus_viol |-> $past(bus_req)) else $error("violation without request"); // R5

   AST_BLOCKED_READS_ZERO: assert property (@(posedge clk) disable iff (!por_n)
      bus_viol |-> (bus_rdata == '0)) else $error("blocked access returned data"); // R6

   AST_NOAUTH_NO_BYPASS: assert property (@(posedge clk) disable iff (!por_n)
      (bus_req && bus_we && (bus_addr < ADDR_W'(NUM_REGS)) && lock_word[2*idx+1] && !dbg_auth)
         |-> !dec.bank_wr) else $error("locked write let through without auth"); // R8

   AST_DBG_KEEPS_LOCKS: assert property (@(posedge clk) disable iff (!por_n)
      (dbg_unlock || scan_mode) |=> (($past(lock_word) & ~lock_word) == '0))
      else $error("debug or scan cleared a lock"); // R8

endmodule

// File: tb/reg_lock_ctrl_tb.sv
module reg_lock_ctrl_tb;

   localparam int N    = 4;
   localparam int DW   = 16;
   localparam int AW   = 3;
   localparam int CFG  = N;
   localparam int LW   = 2 * N + 1;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          req = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          dbg = 1'b0;
   logic          scan = 1'b0;
   logic          auth = 1'b0;
   logic [DW-1:0] rdata;
   logic          viol;

   int checks = 0;
   int fails  = 0;
   logic [DW-1:0] mreg [N];
   logic [LW-1:0] mlock;

   always #10 clk = ~clk;

   reg_lock_ctrl #(.NUM_REGS(N), .DATA_W(DW), .ADDR_W(AW)) u_dut (
      .clk        (clk),
      .por_n      (por_n),
      .bus_req    (req),
      .bus_we     (we),
      .bus_addr   (addr),
      .bus_wdata  (wdata),
      .bus_rdata  (rdata),
      .bus_viol   (viol),
      .dbg_unlock (dbg),
      .scan_mode  (scan),
      .dbg_auth   (auth)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One bus access; expected values come from the requirement model
   task automatic acc(input logic w, input int a, input logic [DW-1:0] d, input string tag);
      logic          byp;
      logic          blk;
      logic [DW-1:0] er;
      byp = (dbg | scan) & auth;
      blk = 1'b0;
      er  = '0;
      if (a < N) begin
         blk = w ? (mlock[2*a+1] & ~byp) : (mlock[2*a] & ~byp);
         if (w && !blk) mreg[a] = d;
         if (!w && !blk) er = mreg[a];
      end else if (a == CFG) begin
         if (w) begin
            if (mlock[LW-1]) blk = 1'b1;
            else mlock = mlock | d[LW-1:0];
         end else begin
            er = DW'(mlock);
         end
      end
      req = 1'b1; we = w; addr = AW'(a); wdata = d;
      @(posedge clk);
      @(negedge clk);
      check({tag, " rdata"}, rdata, er);
      check({tag, " viol"}, DW'(viol), DW'(blk));
   endtask

   task automatic idle();
      req = 1'b0; we = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R5 viol single cycle", DW'(viol), '0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < N; i++) mreg[i] = '0;
      mlock = '0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 rdata at reset", rdata, '0);
      check("R1 viol at reset", DW'(viol), '0);
      acc(1'b0, CFG, '0, "R1 lock word reset");
      for (int i = 0; i < N; i++) acc(1'b0, i, '0, "R1 register reset");

      // R5/R6: unlocked write and readback sweep
      for (int i = 0; i < N; i++) begin
         for (int k = 0; k < 4; k++) begin
            acc(1'b1, i, DW'((i * 16'h1111) ^ (k * 16'h0F0F) ^ 16'h0007), "R5 unlocked write");
            acc(1'b0, i, '0, "R6 unlocked read");
         end
      end
      idle();

      // R10: unmapped addresses
      for (int a = CFG + 1; a < (1 << AW); a++) begin
         acc(1'b1, a, 16'hFFFF, "R10 unmapped write");
         acc(1'b0, a, '0, "R10 unmapped read");
      end
      for (int i = 0; i < N; i++) acc(1'b0, i, '0, "R10 bank untouched");
      acc(1'b0, CFG, '0, "R10 locks untouched");

      // R3: bits above the self-lock are discarded
      acc(1'b1, CFG, 16'hFE00, "R3 upper bits write");
      acc(1'b0, CFG, '0, "R3 upper bits read");

      // R7: lock written in cycle N blocks access in cycle N+1
      acc(1'b1, CFG, 16'h0002, "R7 set write lock reg0");
      acc(1'b1, 0, 16'hBEEF, "R7 next-cycle write blocked");
      acc(1'b0, 0, '0, "R7 reg0 unchanged");
      idle();

      // R2: writing zero never clears
      acc(1'b1, CFG, 16'h0000, "R2 zero write");
      acc(1'b0, CFG, '0, "R2 lock kept");

      // R2/R3/R5/R6: set lock bits one at a time, leave bit 7 open
      for (int b = 0; b < 2 * N - 1; b++) begin
         acc(1'b1, CFG, DW'(1) << b, "R2 set one bit");
         acc(1'b0, CFG, '0, "R3 lock readback");
         for (int i = 0; i < N; i++) begin
            acc(1'b1, i, DW'(16'hA500 + b * 16 + i), "R5 locked sweep write");
            acc(1'b0, i, '0, "R6 locked sweep read");
         end
         idle();
      end

      // R8: debug and scan without authentication
      for (int m = 0; m < 4; m++) begin
         dbg = m[0]; scan = m[1]; auth = 1'b0;
         for (int i = 0; i < N; i++) begin
            acc(1'b1, i, DW'(16'h5A5A ^ i), "R8 write under mode");
            acc(1'b0, i, '0, "R8 read under mode");
         end
         acc(1'b1, CFG, '0, "R8 cfg zero write");
         acc(1'b0, CFG, '0, "R8 cfg unchanged");
      end
      for (int t = 0; t < 8; t++) begin
         dbg = t[0]; scan = t[1];
         idle();
      end
      dbg = 1'b0; scan = 1'b0;
      acc(1'b0, CFG, '0, "R8 locks after toggling");

      // R9: qualifier alone bypasses nothing
      auth = 1'b1;
      for (int i = 0; i < N; i++) begin
         acc(1'b1, i, DW'(16'h3C00 + i), "R9 auth alone write");
         acc(1'b0, i, '0, "R9 auth alone read");
      end
      // R9: authenticated override via each mode
      for (int m = 1; m < 4; m++) begin
         dbg = m[0]; scan = m[1];
         for (int i = 0; i < N; i++) begin
            acc(1'b1, i, DW'(16'hC000 + m * 16 + i), "R9 override write");
            acc(1'b0, i, '0, "R9 override read");
         end
         acc(1'b0, CFG, '0, "R9 locks intact");
      end
      dbg = 1'b0; scan = 1'b0; auth = 1'b0;
      for (int i = 0; i < N; i++) acc(1'b0, i, '0, "R9 locks back after exit");

      // R4: self-lock freezes lock word
      acc(1'b1, CFG, DW'(1) << (LW - 1), "R4 set self-lock");
      acc(1'b1, CFG, DW'(1) << (2 * N - 1), "R4 write after self-lock");
      acc(1'b0, CFG, '0, "R4 lock word frozen");
      acc(1'b1, N - 1, 16'h7777, "R4 open write lock still open");
      acc(1'b0, N - 1, '0, "R4 readback");
      dbg = 1'b1; scan = 1'b1; auth = 1'b1;
      acc(1'b1, CFG, 16'hFFFF, "R9 self-lock under override");
      dbg = 1'b0; scan = 1'b0; auth = 1'b0;
      idle();

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule